// File: doc/BRIEF.md
# Channel Loopback Router

This block steers the sample streams of an eight-channel line interface and the sixteen oversampled serial streams between that interface and the host-side processor. Each channel carries one sample word downstream, from the host toward the line, and one word upstream, from the line toward the host. By default every stream passes straight through. Software can write a small set of control registers to apply test loopbacks:

- a loopback across all channels on the line side;
- a loopback across all channels on the host side;
- a host-side loopback on selected channels only;
- a calibration loopback that pairs one channel with a fixed reference channel;
- a host self-test that returns the host's own outgoing oversampled streams to its receive inputs.

Register writes land in shadow registers, which read back at once. The routing uses a separate active copy, and that copy is loaded only on a frame-boundary strobe, so a sample in flight is never cut.

Only one route applies to a channel at any time. The host self-test ranks highest, followed by the calibration pairing, then the all-channel line loopback, then the all-channel host loopback, and the per-channel host loopback ranks lowest. The data paths are combinational from the stream inputs. Only the mode selection is registered.

Top module: `chan_loopback_ctrl`

## Requirements
- R1: After reset every register reads zero, and every downstream, upstream and oversampled stream passes straight from its input to its output.
- R2: When test register (address 0) bit 0 is active, each channel's downstream output carries that channel's upstream input, and its upstream output keeps its upstream input.
- R3: When test register bit 1 is active and no higher mode applies, each channel's upstream output carries that channel's downstream input, and its downstream output keeps its downstream input.
- R4: Bit n of the channel-loop register (address 1) applies the R3 routing to channel n alone.
- R5: When calibration register (address 2) bit 0 is set and its select field (bits 6:4) names channel s, other than channel 4, two routes apply. Channel s's upstream output carries channel 4's upstream input. Channel 4's downstream output carries channel s's downstream input. All other paths follow the lower-ranked modes.
- R6: A calibration request whose select field names channel 4 has no effect, and every channel follows the lower-ranked modes.
- R7: When self-test register (address 3) bit 0 is active, each oversampled receive output carries the oversampled transmit input of the same index. Otherwise it carries its receive input. The transmit outputs always equal the transmit inputs.
- R8: The modes rank self-test, then calibration, then test bit 0, then test bit 1, then channel-loop. While self-test is active, every channel path passes straight through.
- R9: A register write changes the routing only after the first clock edge that samples the frame strobe high. Until then the previous routing holds.
- R10: Each register reads back its written value. Bits outside the defined fields read zero, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the frame and control domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Frame-boundary strobe that loads the active routing |
| wr_en | input | 1 | Register write enable |
| addr | input | AW (3) | Register address |
| wdata | input | DW (8) | Register write data |
| rd_data | output | DW (8) | Read data for the shadow register at addr |
| ch_dn_in | input | NCH*SW (128) | Per-channel downstream samples from the host |
| ch_up_in | input | NCH*SW (128) | Per-channel upstream samples from the line |
| ch_dn_out | output | NCH*SW (128) | Per-channel downstream samples to the line |
| ch_up_out | output | NCH*SW (128) | Per-channel upstream samples to the host |
| hs_tx_in | input | NHS*OW (16) | Oversampled transmit streams from the host core |
| hs_rx_in | input | NHS*OW (16) | Oversampled receive streams from the line device |
| hs_tx_out | output | NHS*OW (16) | Oversampled transmit streams to the line device |
| hs_rx_out | output | NHS*OW (16) | Oversampled receive streams to the host core |

## Verification
The assertions assume that a write and a frame strobe never fall in the same cycle. They also assume that the stream inputs settle between clock edges, so that a combinational comparison made at the edge sees final values. The stimulus issues every write in its own cycle and pulses the frame strobe alone in a later cycle. It changes the sample inputs only just after a rising edge and samples them on the falling edge. The calibration select is always kept within the eight channels.

// File: rtl/lbk_pkg.sv
`timescale 1ns/1ps
package lbk_pkg;
   typedef enum logic [2:0] {
      PATH_THRU    = 3'd0,
      PATH_ANALOG  = 3'd1,
      PATH_DIGITAL = 3'd2,
      PATH_CAL_SEL = 3'd3,
      PATH_CAL_REF = 3'd4
   } path_e;

   localparam int unsigned REG_TEST = 0;
   localparam int unsigned REG_CHLB = 1;
   localparam int unsigned REG_CAL  = 2;
   localparam int unsigned REG_HOST = 3;

   localparam int unsigned TEST_ANA_BIT = 0;
   localparam int unsigned TEST_DIG_BIT = 1;
   localparam int unsigned CAL_EN_BIT   = 0;
   localparam int unsigned CAL_SEL_LSB  = 4;
   localparam int unsigned HOST_ST_BIT  = 0;
endpackage

// File: rtl/lbk_regs.sv
`timescale 1ns/1ps
module lbk_regs #(
   parameter int NCH  = 8,
   parameter int DW   = 8,
   parameter int AW   = 3,
   parameter int SELW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_tick,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rd_data,
   output logic            act_ana,
   output logic            act_dig,
   output logic [NCH-1:0]  act_mask,
   output logic            act_cal_en,
   output logic [SELW-1:0] act_sel,
   output logic            act_st
);
   import lbk_pkg::*;

   logic            sh_ana, sh_dig, sh_cal_en, sh_st;
   logic [NCH-1:0]  sh_mask;
   logic [SELW-1:0] sh_sel;

   // shadow copy: written by software, read back immediately
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ana    <= 1'b0;
         sh_dig    <= 1'b0;
         sh_mask   <= '0;
         sh_cal_en <= 1'b0;
         sh_sel    <= '0;
         sh_st     <= 1'b0;
      end else if (wr_en) begin
         case (addr)
            AW'(REG_TEST): begin
               sh_ana <= wdata[TEST_ANA_BIT];
               sh_dig <= wdata[TEST_DIG_BIT];
            end
            AW'(REG_CHLB): sh_mask <= wdata[NCH-1:0];
            AW'(REG_CAL): begin
               sh_cal_en <= wdata[CAL_EN_BIT];
               sh_sel    <= wdata[CAL_SEL_LSB +: SELW];
            end
            AW'(REG_HOST): sh_st <= wdata[HOST_ST_BIT];
            default: ;
         endcase
      end
   end

   // active copy: loaded only on a frame boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ana    <= 1'b0;
         act_dig    <= 1'b0;
         act_mask   <= '0;
         act_cal_en <= 1'b0;
         act_sel    <= '0;
         act_st     <= 1'b0;
      end else if (frame_tick) begin
         act_ana    <= sh_ana;
         act_dig    <= sh_dig;
         act_mask   <= sh_mask;
         act_cal_en <= sh_cal_en;
         act_sel    <= sh_sel;
         act_st     <= sh_st;
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         AW'(REG_TEST): begin
            rd_data[TEST_ANA_BIT] = sh_ana;
            rd_data[TEST_DIG_BIT] = sh_dig;
         end
         AW'(REG_CHLB): rd_data[NCH-1:0] = sh_mask;
         AW'(REG_CAL): begin
            rd_data[CAL_EN_BIT]            = sh_cal_en;
            rd_data[CAL_SEL_LSB +: SELW]   = sh_sel;
         end
         AW'(REG_HOST): rd_data[HOST_ST_BIT] = sh_st;
         default: ;
      endcase
   end
endmodule

// File: rtl/lbk_arbiter.sv
`timescale 1ns/1ps
module lbk_arbiter #(
   parameter int NCH    = 8,
   parameter int SELW   = 3,
   parameter int REF_CH = 4
) (
   input  logic                         act_ana,
   input  logic                         act_dig,
   input  logic [NCH-1:0]               act_mask,
   input  logic                         act_cal_en,
   input  logic [SELW-1:0]              act_sel,
   input  logic                         act_st,
   output lbk_pkg::path_e [NCH-1:0]     mode
);
   import lbk_pkg::*;

   logic cal_ok;
   // a request naming the reference channel itself is dropped
   assign cal_ok = act_cal_en && (act_sel != SELW'(REF_CH));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam bit IS_REF = (c == REF_CH);
      logic sel_hit;
      assign sel_hit = cal_ok && (act_sel == SELW'(c));
      always_comb begin
         if (act_st)                       mode[c] = PATH_THRU;
         else if (sel_hit)                 mode[c] = PATH_CAL_SEL;
         else if (cal_ok && IS_REF)        mode[c] = PATH_CAL_REF;
         else if (act_ana)                 mode[c] = PATH_ANALOG;
         else if (act_dig || act_mask[c])  mode[c] = PATH_DIGITAL;
         else                              mode[c] = PATH_THRU;
      end
   end
endmodule

// File: rtl/lbk_xbar.sv
`timescale 1ns/1ps
module lbk_xbar #(
   parameter int NCH    = 8,
   parameter int SW     = 16,
   parameter int SELW   = 3,
   parameter int REF_CH = 4
) (
   input  lbk_pkg::path_e [NCH-1:0] mode,
   input  logic [SELW-1:0]          cal_sel,
   input  logic [NCH*SW-1:0]        dn_in,
   input  logic [NCH*SW-1:0]        up_in,
   output logic [NCH*SW-1:0]        dn_out,
   output logic [NCH*SW-1:0]        up_out
);
   import lbk_pkg::*;

   logic [SW-1:0] dn_a [NCH];
   logic [SW-1:0] up_a [NCH];
   logic [SW-1:0] sel_dn;
   logic [SW-1:0] ref_up;

   for (genvar c = 0; c < NCH; c++) begin : g_unpack
      assign dn_a[c] = dn_in[c*SW +: SW];
      assign up_a[c] = up_in[c*SW +: SW];
   end

   assign sel_dn = dn_a[cal_sel];
   assign ref_up = up_a[REF_CH];

   for (genvar c = 0; c < NCH; c++) begin : g_route
      always_comb begin
         dn_out[c*SW +: SW] = dn_a[c];
         up_out[c*SW +: SW] = up_a[c];
         case (mode[c])
            PATH_ANALOG:  dn_out[c*SW +: SW] = up_a[c];
            PATH_DIGITAL: up_out[c*SW +: SW] = dn_a[c];
            PATH_CAL_SEL: up_out[c*SW +: SW] = ref_up;
            PATH_CAL_REF: dn_out[c*SW +: SW] = sel_dn;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lbk_host_loop.sv
`timescale 1ns/1ps
module lbk_host_loop #(
   parameter int NHS = 16,
   parameter int OW  = 1
) (
   input  logic              st,
   input  logic [NHS*OW-1:0] tx_in,
   input  logic [NHS*OW-1:0] rx_in,
   output logic [NHS*OW-1:0] tx_out,
   output logic [NHS*OW-1:0] rx_out
);
   assign tx_out = tx_in;
   for (genvar s = 0; s < NHS; s++) begin : g_stream
      assign rx_out[s*OW +: OW] = st ? tx_in[s*OW +: OW] : rx_in[s*OW +: OW];
   end
endmodule

// File: rtl/chan_loopback_ctrl.sv
`timescale 1ns/1ps
module chan_loopback_ctrl #(
   parameter int NCH    = 8,
   parameter int SW     = 16,
   parameter int OW     = 1,
   parameter int DW     = 8,
   parameter int AW     = 3,
   parameter int REF_CH = 4,
   localparam int NHS   = 2 * NCH,
   localparam int SELW  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rd_data,
   input  logic [NCH*SW-1:0] ch_dn_in,
   input  logic [NCH*SW-1:0] ch_up_in,
   output logic [NCH*SW-1:0] ch_dn_out,
   output logic [NCH*SW-1:0] ch_up_out,
   input  logic [NHS*OW-1:0] hs_tx_in,
   input  logic [NHS*OW-1:0] hs_rx_in,
   output logic [NHS*OW-1:0] hs_tx_out,
   output logic [NHS*OW-1:0] hs_rx_out
);
   import lbk_pkg::*;

   if (NCH > DW) begin : g_bad_nch
      $error("channel count exceeds register width");
   end
   if (REF_CH >= NCH) begin : g_bad_ref
      $error("reference channel out of range");
   end
   if (CAL_SEL_LSB + SELW > DW) begin : g_bad_sel
      $error("calibration select field does not fit");
   end
   if (AW < 2) begin : g_bad_aw
      $error("address too narrow for four registers");
   end

   logic            act_ana, act_dig, act_cal_en, act_st;
   logic [NCH-1:0]  act_mask;
   logic [SELW-1:0] act_sel;
   path_e [NCH-1:0] mode;

   lbk_regs #(.NCH(NCH), .DW(DW), .AW(AW), .SELW(SELW)) u_regs (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
      .act_ana(act_ana), .act_dig(act_dig), .act_mask(act_mask),
      .act_cal_en(act_cal_en), .act_sel(act_sel), .act_st(act_st)
   );

   lbk_arbiter #(.NCH(NCH), .SELW(SELW), .REF_CH(REF_CH)) u_arb (
      .act_ana(act_ana), .act_dig(act_dig), .act_mask(act_mask),
      .act_cal_en(act_cal_en), .act_sel(act_sel), .act_st(act_st),
      .mode(mode)
   );

   lbk_xbar #(.NCH(NCH), .SW(SW), .SELW(SELW), .REF_CH(REF_CH)) u_xbar (
      .mode(mode), .cal_sel(act_sel),
      .dn_in(ch_dn_in), .up_in(ch_up_in),
      .dn_out(ch_dn_out), .up_out(ch_up_out)
   );

   lbk_host_loop #(.NHS(NHS), .OW(OW)) u_host (
      .st(act_st), .tx_in(hs_tx_in), .rx_in(hs_rx_in),
      .tx_out(hs_tx_out), .rx_out(hs_rx_out)
   );
endmodule

// File: rtl/chan_loopback_ctrl_chk.sv
`timescale 1ns/1ps
module chan_loopback_ctrl_chk #(
   parameter int NCH    = 8,
   parameter int SW     = 16,
   parameter int NHS    = 16,
   parameter int OW     = 1,
   parameter int DW     = 8,
   parameter int AW     = 3,
   parameter int SELW   = 3,
   parameter int REF_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_tick,
   input logic [AW-1:0]     addr,
   input logic [DW-1:0]     rd_data,
   input logic [NCH*SW-1:0] ch_dn_in,
   input logic [NCH*SW-1:0] ch_up_in,
   input logic [NCH*SW-1:0] ch_dn_out,
   input logic [NCH*SW-1:0] ch_up_out,
   input logic [NHS*OW-1:0] hs_tx_in,
   input logic [NHS*OW-1:0] hs_rx_in,
   input logic [NHS*OW-1:0] hs_tx_out,
   input logic [NHS*OW-1:0] hs_rx_out,
   input logic              act_ana,
   input logic              act_dig,
   input logic [NCH-1:0]    act_mask,
   input logic              act_cal_en,
   input logic [SELW-1:0]   act_sel,
   input logic              act_st
);
   // R9: active routing holds between frame strobes
   a_r9_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable({act_ana, act_dig, act_mask, act_cal_en, act_sel, act_st}));

   // R7: self-test returns transmit streams to the receive outputs
   a_r7_selftest_return: assert property (@(posedge clk) disable iff (!rst_n)
      act_st |-> hs_rx_out == hs_tx_in);

   // R7: receive streams pass when self-test is off
   a_r7_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !act_st |-> hs_rx_out == hs_rx_in);

   // R7: transmit streams always pass
   a_r7_tx_pass: assert property (@(posedge clk) disable iff (!rst_n)
      hs_tx_out == hs_tx_in);

   // R8: self-test isolates all channel paths
   a_r8_selftest_isolates: assert property (@(posedge clk) disable iff (!rst_n)
      act_st |-> (ch_dn_out == ch_dn_in) && (ch_up_out == ch_up_in));

   // R2: line-side loopback on every channel
   a_r2_analog_all: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ana && !act_st && !act_cal_en) |-> (ch_dn_out == ch_up_in) && (ch_up_out == ch_up_in));

   // R3: host-side loopback on every channel
   a_r3_digital_all: assert property (@(posedge clk) disable iff (!rst_n)
      (act_dig && !act_ana && !act_st && !act_cal_en) |-> (ch_up_out == ch_dn_in) && (ch_dn_out == ch_dn_in));

   // R6: calibration naming the reference channel changes nothing
   a_r6_ref_select_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cal_en && act_sel == SELW'(REF_CH) && !act_st && !act_ana && !act_dig && act_mask == '0)
      |-> (ch_dn_out == ch_dn_in) && (ch_up_out == ch_up_in));

   // R10: unused bits of the test register read zero
   a_r10_test_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(0)) |-> rd_data[DW-1:2] == '0);
endmodule

bind chan_loopback_ctrl chan_loopback_ctrl_chk #(
   .NCH(NCH), .SW(SW), .NHS(NHS), .OW(OW), .DW(DW), .AW(AW), .SELW(SELW), .REF_CH(REF_CH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .addr(addr), .rd_data(rd_data),
   .ch_dn_in(ch_dn_in), .ch_up_in(ch_up_in), .ch_dn_out(ch_dn_out), .ch_up_out(ch_up_out),
   .hs_tx_in(hs_tx_in), .hs_rx_in(hs_rx_in), .hs_tx_out(hs_tx_out), .hs_rx_out(hs_rx_out),
   .act_ana(act_ana), .act_dig(act_dig), .act_mask(act_mask),
   .act_cal_en(act_cal_en), .act_sel(act_sel), .act_st(act_st)
);

// File: tb/chan_loopback_ctrl_tb.sv
`timescale 1ns/1ps
module chan_loopback_ctrl_tb;
   localparam int NCH = 8, SW = 16, OW = 1, DW = 8, AW = 3, REF_CH = 4;
   localparam int NHS = 2 * NCH;
   localparam int VW  = NCH * SW;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0, rd_data;
   logic [VW-1:0] ch_dn_in = '0, ch_up_in = '0, ch_dn_out, ch_up_out;
   logic [NHS*OW-1:0] hs_tx_in = '0, hs_rx_in = '0, hs_tx_out, hs_rx_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_loopback_ctrl #(.NCH(NCH), .SW(SW), .OW(OW), .DW(DW), .AW(AW), .REF_CH(REF_CH)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rd_data(rd_data),
      .ch_dn_in(ch_dn_in), .ch_up_in(ch_up_in), .ch_dn_out(ch_dn_out), .ch_up_out(ch_up_out),
      .hs_tx_in(hs_tx_in), .hs_rx_in(hs_rx_in), .hs_tx_out(hs_tx_out), .hs_rx_out(hs_rx_out)
   );

   typedef struct {
      string         req;
      int            kind;
      logic [VW-1:0] exp;
   } item_t;
   item_t q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // bench register model: shadow and active copies
   logic s_ana = 0, s_dig = 0, s_cal = 0, s_st = 0;
   logic [NCH-1:0] s_mask = '0;
   logic [2:0] s_sel = '0;
   logic a_ana = 0, a_dig = 0, a_cal = 0, a_st = 0;
   logic [NCH-1:0] a_mask = '0;
   logic [2:0] a_sel = '0;

   function automatic void push(string req, int kind, logic [VW-1:0] exp);
      item_t it;
      it.req = req; it.kind = kind; it.exp = exp;
      q.push_back(it);
   endfunction

   // monitor: compare queued expectations on the falling edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [VW-1:0] act;
         it = q.pop_front();
         case (it.kind)
            0: act = ch_dn_out;
            1: act = ch_up_out;
            2: act = VW'(hs_rx_out);
            3: act = VW'(hs_tx_out);
            default: act = VW'(rd_data);
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      case (a)
         0: begin s_ana = d[0]; s_dig = d[1]; end
         1: s_mask = d[NCH-1:0];
         2: begin s_cal = d[0]; s_sel = d[6:4]; end
         3: s_st = d[0];
         default: ;
      endcase
   endtask

   task automatic tick();
      @(posedge clk); #1;
      frame_tick = 1'b1;
      @(posedge clk); #1;
      frame_tick = 1'b0;
      a_ana = s_ana; a_dig = s_dig; a_mask = s_mask;
      a_cal = s_cal; a_sel = s_sel; a_st = s_st;
   endtask

   function automatic logic [DW-1:0] rd_model(int a);
      case (a)
         0: return {6'b0, s_dig, s_ana};
         1: return s_mask;
         2: return {1'b0, s_sel, 3'b0, s_cal};
         3: return {7'b0, s_st};
         default: return '0;
      endcase
   endfunction

   task automatic rd(input int a, input string req);
      @(posedge clk); #1;
      addr = AW'(a);
      push(req, 4, VW'(rd_model(a)));
   endtask

   task automatic check_paths(input string req);
      logic [VW-1:0] dn_e, up_e;
      logic cal_ok;
      @(posedge clk); #1;
      ch_dn_in = {$urandom, $urandom, $urandom, $urandom};
      ch_up_in = {$urandom, $urandom, $urandom, $urandom};
      hs_tx_in = NHS'($urandom);
      hs_rx_in = NHS'($urandom);
      dn_e = ch_dn_in; up_e = ch_up_in;
      cal_ok = a_cal && (a_sel != 3'(REF_CH));
      for (int c = 0; c < NCH; c++) begin
         if (a_st) begin
         end else if (cal_ok && a_sel == 3'(c)) begin
            up_e[c*SW +: SW] = ch_up_in[REF_CH*SW +: SW];
         end else if (cal_ok && c == REF_CH) begin
            dn_e[c*SW +: SW] = ch_dn_in[a_sel*SW +: SW];
         end else if (a_ana) begin
            dn_e[c*SW +: SW] = ch_up_in[c*SW +: SW];
         end else if (a_dig || a_mask[c]) begin
            up_e[c*SW +: SW] = ch_dn_in[c*SW +: SW];
         end
      end
      push(req, 0, dn_e);
      push(req, 1, up_e);
      push(req, 2, VW'(a_st ? hs_tx_in : hs_rx_in));
      push(req, 3, VW'(hs_tx_in));
   endtask

   task automatic clear_all();
      wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 4; a++) rd(a, "R1");
      check_paths("R1");
      // R10: readback and masking of undefined bits
      wr(0, 8'hFF); rd(0, "R10");
      wr(1, 8'hA5); rd(1, "R10");
      wr(2, 8'hFF); rd(2, "R10");
      wr(3, 8'hFF); rd(3, "R10");
      rd(5, "R10");
      // R9: nothing active before a frame strobe
      check_paths("R9");
      tick();
      // R8: self-test overrides every channel mode
      check_paths("R8");
      check_paths("R7");
      clear_all();
      // R2: line-side loopback on all channels
      wr(0, 8'h01); tick();
      check_paths("R2"); check_paths("R2");
      // R3: host-side loopback on all channels
      wr(0, 8'h02);
      check_paths("R9");
      tick();
      check_paths("R3");
      // R8: analog outranks digital
      wr(0, 8'h03); tick(); check_paths("R8");
      // R4: per-channel loop
      wr(0, 8'h00); wr(1, 8'h81); tick(); check_paths("R4");
      wr(1, 8'h5A); tick(); check_paths("R4");
      // R5: calibration over analog and per-channel
      wr(0, 8'h01); wr(2, 8'h21); wr(1, 8'h81); tick(); check_paths("R5");
      wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h71); tick(); check_paths("R5");
      wr(2, 8'h01); tick(); check_paths("R5");
      // R6: selecting the reference channel is ignored
      wr(2, 8'h41); wr(1, 8'h10); tick(); check_paths("R6");
      wr(1, 8'h00); tick(); check_paths("R6");
      // R7: host self-test on and off
      wr(3, 8'h01); tick(); check_paths("R7");
      wr(3, 8'h00); tick(); check_paths("R7");
      rd(2, "R10"); rd(3, "R10");
      @(posedge clk); @(negedge clk); #1;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule